// File: doc/BRIEF.md
# Peripheral Bus Descriptor List Walker

This engine follows a chain of transfer descriptors held in memory. A start pulse supplies the address of the first descriptor. The engine fetches each header word over a 32-bit read port and decodes three fields: a final-entry flag, a pattern code and a payload length. Most patterns are a single word. The engine skips past them, and the bus-claim pattern also emits a one-cycle notification that names one of four buses. A start-type descriptor has a receive address and a payload behind its header. The engine streams the payload words to a device port and writes every reply word to memory, starting at the receive address.

Frame words travel between memory and the device port in one of two byte orders, chosen by a single input. When the last descriptor in the chain has been handled, the engine raises done for one cycle and drops busy. All memory traffic uses one outstanding request at a time with an acknowledge, so slow memory simply stretches the walk.

Top module: `pbus_desc_walker`

## Requirements
- R1: While reset is held and right after it, busy, done, rd_req, wr_req, tx_valid, rx_ready and occ_valid are all low.
- R2: In a header word, bit 31 set marks the final descriptor, bits 10:8 hold the pattern code and bits 7:0 hold the payload length in words minus one.
- R3: A header with any pattern code other than 0 occupies one word, and the next header is read 4 bytes later. Codes 3, 4, 7 and all undefined codes cause no other activity.
- R4: A header with pattern code 2 produces a one-cycle occ_valid pulse, with occ_bus equal to header bits 17:16.
- R5: For pattern code 0, the word after the header is the receive address, ANDed with 0x1FFFFFE0. Reply word j is written to that address plus 4*j.
- R6: For pattern code 0, the payload words at header address + 8 + 4*i (i = 0 to length) are offered on the device port in order, with tx_last set only on word i = length. The next header is read at header address + 8 + 4*(length+1).
- R7: When order_sel is 0, every payload word sent to the device and every reply word written to memory is byte-reversed (bits 7:0 swap with 31:24, and 15:8 swap with 23:16). When order_sel is 1, words pass unchanged.
- R8: A reply beat that has rx_absent set ends the reply, and the single word 0xFFFFFFFF is written to the receive address.
- R9: busy rises the cycle after an accepted start and stays high until done. done is a one-cycle pulse that follows the final memory write of the descriptor with bit 31 set. A start pulse that arrives while busy is ignored.
- R10: A read request, write request or device word is held with stable address and data until its acknowledge or ready arrives.
- R11: At most one of rd_req, wr_req, tx_valid and rx_ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at base_addr (ignored while busy) |
| base_addr | input | AW | Address of the first descriptor |
| order_sel | input | 1 | 0: byte-reverse frame words, 1: pass unchanged |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at end of the walk |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read accepted; rd_data valid |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | AW | Write address |
| wr_data | output | 32 | Write data |
| wr_ack | input | 1 | Write accepted |
| tx_valid | output | 1 | Frame word offered to device |
| tx_data | output | 32 | Frame word |
| tx_last | output | 1 | Final frame word of the descriptor |
| tx_ready | input | 1 | Device accepts the frame word |
| rx_valid | input | 1 | Reply word from device |
| rx_data | input | 32 | Reply word |
| rx_last | input | 1 | Final reply word |
| rx_absent | input | 1 | No device answered the recipient |
| rx_ready | output | 1 | Engine accepts a reply word |
| occ_valid | output | 1 | Bus-claim pattern seen |
| occ_bus | output | 2 | Bus named by the bus-claim pattern |

## Verification
The hold properties assume that memory and the device keep each acknowledge or ready to a single cycle and never raise it without a pending request. They also assume that order_sel does not change during a walk. The bench responders raise each acknowledge only against a live request and drop it the following cycle, with a stall before it that varies from one walk to the next. order_sel is changed only while the engine is idle. The reply model produces rx_valid only after the last frame word has been accepted, so no reply overlaps a pending memory access.

// File: rtl/pbus_desc_walker.sv
module pbus_desc_walker #(
  parameter int AW = 32,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          order_sel,
  output logic          busy,
  output logic          done,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [31:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ack,
  output logic          tx_valid,
  output logic [31:0]   tx_data,
  output logic          tx_last,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [31:0]   rx_data,
  input  logic          rx_last,
  input  logic          rx_absent,
  output logic          rx_ready,
  output logic          occ_valid,
  output logic [1:0]    occ_bus
);
  localparam logic [AW-1:0] RX_MASK = AW'(32'h1FFF_FFE0);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RXA, S_PAY, S_TX, S_RX, S_WR} st_t;
  st_t st;

  logic [AW-1:0] addr, rxa;
  logic [31:0]   hdr, word;
  logic [CW-1:0] cnt;
  logic          wlast;

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  wire           swp     = ~order_sel;
  wire [AW-1:0]  off     = AW'({cnt, 2'b00});
  wire [AW-1:0]  nxt     = addr + AW'(8) + AW'({({1'b0, hdr[7:0]} + 9'd1), 2'b00});

  assign busy     = st != S_IDLE;
  assign rd_req   = st == S_HDR || st == S_RXA || st == S_PAY;
  assign wr_req   = st == S_WR;
  assign tx_valid = st == S_TX;
  assign rx_ready = st == S_RX;
  assign wr_addr  = rxa + off;
  assign wr_data  = word;
  assign tx_data  = word;
  assign tx_last  = cnt == CW'(hdr[7:0]);

  always_comb begin
    case (st)
      S_RXA:   rd_addr = addr + AW'(4);
      S_PAY:   rd_addr = addr + AW'(8) + off;
      default: rd_addr = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; rxa <= '0; hdr <= '0; word <= '0;
      cnt <= '0; wlast <= 1'b0; done <= 1'b0; occ_valid <= 1'b0; occ_bus <= '0;
    end else begin
      done      <= 1'b0;
      occ_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin addr <= base_addr; st <= S_HDR; end
        S_HDR: if (rd_ack) begin
          hdr <= rd_data;
          if (rd_data[10:8] == 3'd0) st <= S_RXA;
          else begin
            if (rd_data[10:8] == 3'd2) begin
              occ_valid <= 1'b1;
              occ_bus   <= rd_data[17:16];
            end
            if (rd_data[31]) begin st <= S_IDLE; done <= 1'b1; end
            else addr <= addr + AW'(4);
          end
        end
        S_RXA: if (rd_ack) begin
          rxa <= rd_data[AW-1:0] & RX_MASK;
          cnt <= '0;
          st  <= S_PAY;
        end
        S_PAY: if (rd_ack) begin
          word <= swp ? rev(rd_data) : rd_data;
          st   <= S_TX;
        end
        S_TX: if (tx_ready) begin
          if (tx_last) begin cnt <= '0; st <= S_RX; end
          else begin cnt <= cnt + 1'b1; st <= S_PAY; end
        end
        S_RX: if (rx_valid) begin
          word  <= rx_absent ? 32'hFFFF_FFFF : (swp ? rev(rx_data) : rx_data);
          wlast <= rx_absent | rx_last;
          st    <= S_WR;
        end
        S_WR: if (wr_ack) begin
          if (wlast) begin
            if (hdr[31]) begin st <= S_IDLE; done <= 1'b1; end
            else begin addr <= nxt; st <= S_HDR; end
          end else begin
            cnt <= cnt + 1'b1;
            st  <= S_RX;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R11
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, wr_req, tx_valid, rx_ready}));
  // R4
  occ_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_valid |-> $past(rd_req) && $past(rd_ack) && $past(rd_data[10:8]) == 3'd2);
endmodule

// File: tb/pbus_desc_walker_tb.sv
module pbus_desc_walker_tb;
  localparam int CLK_P = 10;
  localparam int NV = 5;
  // {order_sel, absent, len[5:0], nrep[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd0, 8'd1},
    {1'b0, 1'b0, 6'd2, 8'd3},
    {1'b1, 1'b0, 6'd3, 8'd2},
    {1'b0, 1'b1, 6'd1, 8'd1},
    {1'b0, 1'b0, 6'd0, 8'd4}
  };

  logic clk = 0, rst_n = 0, start = 0, order_sel = 1;
  logic [31:0] base_addr = 0;
  logic busy, done, rd_req, wr_req, tx_valid, tx_last, rx_ready, occ_valid;
  logic [31:0] rd_addr, wr_addr, wr_data, tx_data;
  logic [1:0] occ_bus;
  logic rd_ack = 0, wr_ack = 0, tx_ready = 0, rx_valid = 0, rx_last = 0, rx_absent = 0;
  logic [31:0] rd_data = 0, rx_data = 0;

  pbus_desc_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .order_sel(order_sel),
    .busy(busy), .done(done), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_absent(rx_absent), .rx_ready(rx_ready), .occ_valid(occ_valid), .occ_bus(occ_bus));

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [0:63];
  int stall = 0, rep_n = 1;
  logic rep_abs = 0, log_clr = 0;
  int rwait = 0, wwait = 0, rx_left = 0, rx_idx = 0;

  logic [31:0] rd_log [0:31], tx_log [0:31], wa_log [0:31], wd_log [0:31];
  logic tl_log [0:31];
  int rd_n = 0, tx_n = 0, wr_n = 0, occ_n = 0, done_n = 0;
  logic [1:0] occ_b = 0;
  int errs = 0, checks = 0;

  function automatic logic [31:0] brev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk) begin
    if (rd_ack) rd_ack <= 0;
    else if (rd_req) begin
      if (rwait > 0) rwait <= rwait - 1;
      else begin rd_ack <= 1; rd_data <= mem[rd_addr[7:2]]; rwait <= stall; end
    end
    if (wr_ack) wr_ack <= 0;
    else if (wr_req) begin
      if (wwait > 0) wwait <= wwait - 1;
      else begin wr_ack <= 1; wwait <= stall; end
    end
    if (tx_ready) tx_ready <= 0;
    else if (tx_valid) tx_ready <= 1;
    if (rx_valid && rx_ready) rx_valid <= 0;
    else if (rx_left > 0 && !rx_valid) begin
      rx_valid <= 1; rx_data <= 32'h5566_7700 + rx_idx;
      rx_last <= (rx_left == 1); rx_absent <= rep_abs;
      rx_left <= rx_left - 1; rx_idx <= rx_idx + 1;
    end
    if (tx_valid && tx_ready && tx_last) begin rx_left <= rep_n; rx_idx <= 0; end
  end

  always @(posedge clk) begin
    if (log_clr) begin
      rd_n <= 0; tx_n <= 0; wr_n <= 0; occ_n <= 0; done_n <= 0;
    end else begin
      if (rd_req && rd_ack && rd_n < 32) begin rd_log[rd_n] <= rd_addr; rd_n <= rd_n + 1; end
      if (tx_valid && tx_ready && tx_n < 32) begin
        tx_log[tx_n] <= tx_data; tl_log[tx_n] <= tx_last; tx_n <= tx_n + 1;
      end
      if (wr_req && wr_ack && wr_n < 32) begin
        wa_log[wr_n] <= wr_addr; wd_log[wr_n] <= wr_data; wr_n <= wr_n + 1;
      end
      if (occ_valid) begin occ_n <= occ_n + 1; occ_b <= occ_bus; end
      if (done) done_n <= done_n + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] base, input bit poke);
    @(negedge clk) log_clr = 1;
    @(negedge clk) log_clr = 0; base_addr = base; start = 1;
    @(negedge clk) start = 0;
    chk(busy === 1'b1, "R9 busy after start", {31'b0, busy}, 1);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (poke && c == 6) begin start = 1; base_addr = 0; end
      if (poke && c == 7) start = 0;
      if (done) break;
    end
    repeat (4) @(negedge clk);
    chk(done_n == 1, "R9 single done", done_n, 1);
    chk(busy === 1'b0, "R9 idle after done", {31'b0, busy}, 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, rd_req, wr_req, tx_valid, rx_ready, occ_valid} === 7'b0,
        "R1 in reset", {25'b0, busy, done, rd_req, wr_req, tx_valid, rx_ready, occ_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, rd_req, wr_req, tx_valid, rx_ready, occ_valid} === 7'b0,
        "R1 after reset", {25'b0, busy, done, rd_req, wr_req, tx_valid, rx_ready, occ_valid}, 0);

    for (int v = 0; v < NV; v++) begin
      automatic logic ord = VEC[v][15];
      automatic logic abs = VEC[v][14];
      automatic int len = int'(VEC[v][13:8]);
      automatic int nr = int'(VEC[v][7:0]);
      automatic logic [31:0] w, e;
      order_sel = ord; rep_n = nr; rep_abs = abs; stall = v % 3;
      mem[0] = 32'h8000_0000 | len;
      mem[1] = 32'hE000_013F;
      for (int i = 0; i <= len; i++) mem[2+i] = 32'hA1B2_C300 + i;
      run(0, 0);
      // R2 R6 reads are sequential words
      chk(rd_n == len + 3, "R6 read count", rd_n, len + 3);
      for (int i = 0; i < len + 3 && i < 32; i++)
        chk(rd_log[i] == 4*i, "R6 read addr", rd_log[i], 4*i);
      chk(tx_n == len + 1, "R6 tx count", tx_n, len + 1);
      for (int i = 0; i <= len && i < 32; i++) begin
        w = 32'hA1B2_C300 + i;
        e = ord ? w : brev(w);
        chk(tx_log[i] == e, "R7 tx data", tx_log[i], e);
        chk(tl_log[i] == (i == len), "R6 tx_last", {31'b0, tl_log[i]}, {31'b0, i == len});
      end
      chk(wr_n == nr, "R5 write count", wr_n, nr);
      for (int j = 0; j < nr && j < 32; j++) begin
        w = 32'h5566_7700 + j;
        e = abs ? 32'hFFFF_FFFF : (ord ? w : brev(w));
        chk(wa_log[j] == 32'h120 + 4*j, "R5 write addr", wa_log[j], 32'h120 + 4*j);
        chk(wd_log[j] == e, abs ? "R8 absent word" : "R7 reply data", wd_log[j], e);
      end
      chk(occ_n == 0, "R3 no occ", occ_n, 0);
    end

    // R3 R4 R6 R9 chain with mixed patterns and a start while busy
    mem[32] = 32'h0000_0700;
    mem[33] = 32'h0003_0200;
    mem[34] = 32'h0000_0500;
    mem[35] = 32'h0000_0001;
    mem[36] = 32'h0000_0240;
    mem[37] = 32'h0102_0304;
    mem[38] = 32'h0506_0708;
    mem[39] = 32'h8000_0300;
    order_sel = 1; rep_n = 2; rep_abs = 0; stall = 2;
    run(32'h80, 1);
    chk(rd_n == 8, "R3 chain read count", rd_n, 8);
    for (int i = 0; i < 8; i++)
      chk(rd_log[i] == 32'h80 + 4*i, "R3 chain read addr", rd_log[i], 32'h80 + 4*i);
    chk(occ_n == 1, "R4 occ count", occ_n, 1);
    chk({30'b0, occ_b} == 3, "R4 occ bus", {30'b0, occ_b}, 3);
    chk(tx_n == 2 && tx_log[1] == 32'h0506_0708, "R6 chain payload", tx_log[1], 32'h0506_0708);
    chk(wr_n == 2 && wa_log[1] == 32'h244, "R5 chain reply addr", wa_log[1], 32'h244);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule